// File: doc/BRIEF.md
# Instruction Address Translation Buffer with Pairwise-Order Replacement

This block is a small fully associative translation buffer for the instruction fetch path. It holds four page translations. Each entry carries its own page size, so one entry can cover anything from 1 KB up to 1 MB. A fetch unit offers a virtual address, an address-space identifier (ASID) and an enable for the ASID comparison. One cycle later the block answers with one of two results: a hit (entry index and physical address) or a multi-hit. If nothing matches, the block instead asks the larger unified translation buffer for the entry. It then waits for that entry on a refill port and writes it over the entry that was used least recently. Recency is held in a 6-bit code. Each bit records the order of one pair of entries.

The lookup, miss and refill paths are valid/ready handshakes. The lookup side is ready only while no miss is outstanding and no invalidate is being applied. The miss request holds its address and ASID stable until it is accepted. The refill port is ready only after the miss request has been accepted. The result has no ready signal, so the fetch side must take each result pulse in the cycle it appears. A plain invalidate input drops every entry at once. A read port exposes any entry's tag and data words for inspection.

Top module: `itlb_quad`

## Requirements
- R1: Flag bits 7 and 4 set an entry's page size: 00 means 1 KB, 01 means 4 KB, 10 means 64 KB and 11 means 1 MB. The virtual page comparison covers address bits 31:10, 31:12, 31:16 or 31:20 respectively.
- R2: An entry matches under three conditions. Its valid flag (bit 8) must be set. Its page number must equal the address under its size mask. Either its shared flag (bit 1) is set, or its ASID equals the request ASID, or the ASID-check enable is low.
- R3: When two or more entries match, the result carries res_multi=1 and res_hit=0, and the recency code is left unchanged.
- R4: The victim comes from the 6-bit recency code, tested in this order. If code&0x38 equals 0x38, entry 0 is chosen. Otherwise, if code&0x26 equals 0x06, entry 1 is chosen. Otherwise, if code&0x15 equals 0x01, entry 2 is chosen. Otherwise entry 3 is chosen. The code resets to 0, so refills after reset fill entries 3, 2, 1, 0 in that order.
- R5: A single hit on entry i, or a refill of entry i, updates the code as follows. Entry 0 gives code&0x07. Entry 1 gives (code&0x19)|0x20. Entry 2 gives (code&0x3E)|0x14. Entry 3 gives code|0x0B.
- R6: A refill stores the flags ANDed with 0x1DA.
- R7: On a miss, miss_valid rises in the cycle after the lookup is accepted. The address stays stable until miss_ready is seen, and lk_ready stays low until the refill completes.
- R8: While invalidate is high, lk_ready and fill_ready are low. The valid flag of every entry is clear in the cycle that follows.
- R9: The read port selects an entry with address bits 8:7. The tag word is {page number bits 31:10, 0, valid, ASID[7:0]}. The data word is {physical page bits 28:10, 0, flags[8:0]}.
- R10: The physical address is the entry's physical page under the size mask, ORed with the virtual address bits outside the mask.
- R11: After reset, lk_ready=1, res_valid=0, miss_valid=0, fill_ready=0 and every entry is invalid.
- R12: res_valid pulses for one cycle. It comes in the cycle after a lookup hits or multi-hits, or in the cycle after a refill is accepted. For a refill, it reports a hit on the refilled entry and the address translated through the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current ASID |
| lk_asid_chk | input | 1 | Enable ASID comparison |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Single match or refill |
| res_multi | output | 1 | More than one entry matched |
| res_idx | output | 2 | Entry that supplied the translation |
| res_paddr | output | 29 | Translated physical address |
| miss_valid | output | 1 | Request to the unified buffer |
| miss_ready | input | 1 | Unified buffer accepts the request |
| miss_vaddr | output | 32 | Missing virtual address |
| miss_asid | output | 8 | ASID of the missing request |
| fill_valid | input | 1 | Refill entry valid |
| fill_ready | output | 1 | Refill accepted |
| fill_vpn | input | 22 | Refill virtual page, address bits 31:10 |
| fill_ppn | input | 19 | Refill physical page, address bits 28:10 |
| fill_asid | input | 8 | Refill ASID |
| fill_flags | input | 9 | Refill flags before masking |
| rd_addr | input | 2 | Inspection address bits 8:7 |
| rd_tag | output | 32 | Tag word of the selected entry |
| rd_data | output | 32 | Data word of the selected entry |

## Verification
The bench walks the recency code through a full cycle of refills, then through hits on entries 3 and 0. A wrong select mask or update pattern therefore shows up as the wrong victim index on a later refill. It places a 1 MB entry over a 4 KB entry and looks the address up with the ASID check off. A design that takes the first match, instead of flagging the conflict, would report a hit. It crosses 1 KB and 4 KB page boundaries and hits a shared 64 KB entry under a foreign ASID, so a wrong size mask or a shared flag that is not honoured shows up as a miss or a wrong address. It also stalls the miss handshake and invalidates mid-run. A design that dropped the held address, or kept stale valid flags, would give the wrong miss address or a hit where a miss is expected.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int ENTRIES    = 4;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int LRU_W      = 6;
  localparam int VA_W       = 32;
  localparam int PA_W       = 29;
  localparam int ASID_W     = 8;
  localparam int FLAG_W     = 9;
  localparam int PAGE_LSB   = 10;
  localparam int VPN_W      = VA_W - PAGE_LSB;
  localparam int PPN_W      = PA_W - PAGE_LSB;
  localparam int RD_IDX_LSB = 7;

  // flag bit positions
  localparam int F_VALID  = 8;
  localparam int F_SZ_HI  = 7;
  localparam int F_SZ_LO  = 4;
  localparam int F_SHARED = 1;
  localparam logic [FLAG_W-1:0] FILL_KEEP = 9'h1DA;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LRU_W-1:0] lru_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } entry_t;

  function automatic int page_shift(input logic [FLAG_W-1:0] f);
    case ({f[F_SZ_HI], f[F_SZ_LO]})
      2'b00:   return 10;
      2'b01:   return 12;
      2'b10:   return 16;
      default: return 20;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] size_mask(input logic [FLAG_W-1:0] f);
    return {VA_W{1'b1}} << page_shift(f);
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [FLAG_W-1:0] f,
                                              input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    logic [PA_W-1:0] base;
    m    = size_mask(f);
    base = {ppn, {PAGE_LSB{1'b0}}};
    return (base & m[PA_W-1:0]) | (va[PA_W-1:0] & ~m[PA_W-1:0]);
  endfunction

  function automatic idx_t lru_victim(input lru_t c);
    if ((c & 6'h38) == 6'h38)      return idx_t'(0);
    else if ((c & 6'h26) == 6'h06) return idx_t'(1);
    else if ((c & 6'h15) == 6'h01) return idx_t'(2);
    else                           return idx_t'(3);
  endfunction

  function automatic lru_t lru_touch(input lru_t c, input idx_t i);
    case (i)
      idx_t'(0): return c & 6'h07;
      idx_t'(1): return (c & 6'h19) | 6'h20;
      idx_t'(2): return (c & 6'h3E) | 6'h14;
      default:   return c | 6'h0B;
    endcase
  endfunction
endpackage

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  idx_t                   wr_idx,
  input  entry_t                 wr_ent,
  output entry_t [ENTRIES-1:0]   ent_q
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    entry_t e_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_r <= '0;
      end else if (wr_en && (wr_idx == idx_t'(g))) begin
        e_r <= wr_ent;
      end else if (flush) begin
        e_r.flags[F_VALID] <= 1'b0;
      end
    end
    assign ent_q[g] = e_r;
  end
endmodule

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
(
  input  entry_t [ENTRIES-1:0] ent,
  input  logic [VA_W-1:0]      vaddr,
  input  logic [ASID_W-1:0]    asid,
  input  logic                 asid_chk,
  output logic                 any_hit,
  output logic                 multi_hit,
  output idx_t                 hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VA_W-1:0] m;
    logic [VA_W-1:0] tag;
    logic            page_eq;
    logic            asid_ok;
    assign m       = size_mask(ent[g].flags);
    assign tag     = {ent[g].vpn, {PAGE_LSB{1'b0}}};
    assign page_eq = ((tag ^ vaddr) & m) == '0;
    assign asid_ok = !asid_chk || ent[g].flags[F_SHARED] || (ent[g].asid == asid);
    assign hit_vec[g] = ent[g].flags[F_VALID] && page_eq && asid_ok;
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = (hit_vec & (hit_vec - ENTRIES'(1))) != '0;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = idx_t'(i);
    end
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic touch,
  input  idx_t touch_idx,
  output idx_t victim
);
  lru_t code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (touch) code_q <= lru_touch(code_q, touch_idx);
  end

  assign victim = lru_victim(code_q);
endmodule

// File: rtl/itlb_quad.sv
module itlb_quad
  import itlb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       lk_valid,
  output logic                       lk_ready,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic                       lk_asid_chk,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic                       res_multi,
  output logic [IDX_W-1:0]           res_idx,
  output logic [PA_W-1:0]            res_paddr,
  output logic                       miss_valid,
  input  logic                       miss_ready,
  output logic [VA_W-1:0]            miss_vaddr,
  output logic [ASID_W-1:0]          miss_asid,
  input  logic                       fill_valid,
  output logic                       fill_ready,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [PPN_W-1:0]           fill_ppn,
  input  logic [ASID_W-1:0]          fill_asid,
  input  logic [FLAG_W-1:0]          fill_flags,
  input  logic [IDX_W-1:0]           rd_addr,
  output logic [VA_W-1:0]            rd_tag,
  output logic [VA_W-1:0]            rd_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_WAIT} state_t;

  state_t               state_q;
  logic [VA_W-1:0]      pend_va_q;
  logic [ASID_W-1:0]    pend_asid_q;
  entry_t [ENTRIES-1:0] ent;
  logic [ENTRIES-1:0]   ent_valid;
  logic                 any_hit, multi_hit;
  idx_t                 hit_idx, victim;
  logic                 lk_fire, fill_fire, touch;
  idx_t                 touch_idx;
  entry_t               fill_ent;

  assign lk_ready   = (state_q == ST_IDLE) && !flush;
  assign fill_ready = (state_q == ST_WAIT) && !flush;
  assign miss_valid = (state_q == ST_ASK);
  assign miss_vaddr = pend_va_q;
  assign miss_asid  = pend_asid_q;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign ent_valid[g] = ent[g].flags[F_VALID];
  end

  assign fill_ent = '{vpn:   fill_vpn,
                      asid:  fill_asid,
                      ppn:   fill_ppn,
                      flags: fill_flags & FILL_KEEP};

  itlb_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .wr_en  (fill_fire),
    .wr_idx (victim),
    .wr_ent (fill_ent),
    .ent_q  (ent)
  );

  itlb_match u_match (
    .ent       (ent),
    .vaddr     (lk_vaddr),
    .asid      (lk_asid),
    .asid_chk  (lk_asid_chk),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .hit_idx   (hit_idx)
  );

  assign touch     = fill_fire || (lk_fire && any_hit && !multi_hit);
  assign touch_idx = fill_fire ? victim : hit_idx;

  itlb_lru u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_va_q   <= '0;
      pend_asid_q <= '0;
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_multi   <= 1'b0;
      res_idx     <= '0;
      res_paddr   <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (lk_fire) begin
            if (multi_hit) begin
              res_valid <= 1'b1;
              res_hit   <= 1'b0;
              res_multi <= 1'b1;
              res_idx   <= '0;
              res_paddr <= '0;
            end else if (any_hit) begin
              res_valid <= 1'b1;
              res_hit   <= 1'b1;
              res_multi <= 1'b0;
              res_idx   <= hit_idx;
              res_paddr <= make_pa(ent[hit_idx].ppn, ent[hit_idx].flags, lk_vaddr);
            end else begin
              state_q     <= ST_ASK;
              pend_va_q   <= lk_vaddr;
              pend_asid_q <= lk_asid;
            end
          end
        end
        ST_ASK: begin
          if (miss_ready) state_q <= ST_WAIT;
        end
        default: begin
          if (fill_fire) begin
            state_q   <= ST_IDLE;
            res_valid <= 1'b1;
            res_hit   <= 1'b1;
            res_multi <= 1'b0;
            res_idx   <= victim;
            res_paddr <= make_pa(fill_ppn, fill_ent.flags, pend_va_q);
          end
        end
      endcase
    end
  end

  // inspection port
  entry_t rd_ent;
  assign rd_ent  = ent[rd_addr];
  assign rd_tag  = {rd_ent.vpn, {(PAGE_LSB-ASID_W-1){1'b0}}, rd_ent.flags[F_VALID], rd_ent.asid};
  assign rd_data = {{(VA_W-PA_W){1'b0}}, rd_ent.ppn, {(PAGE_LSB-FLAG_W){1'b0}}, rd_ent.flags};
endmodule

// File: rtl/itlb_quad_chk.sv
module itlb_quad_chk
  import itlb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               res_valid,
  input logic               res_hit,
  input logic               res_multi,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic [VA_W-1:0]    miss_vaddr,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic [ENTRIES-1:0] ent_valid
);
  // R3
  multi_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_multi) |-> !res_hit);

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_vaddr)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid || fill_ready) |-> !lk_ready);

  // R8
  flush_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lk_ready && !fill_ready));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0));

  // R12
  res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past((lk_valid && lk_ready) || (fill_valid && fill_ready)));

  // R7
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_valid, fill_ready, lk_ready}));
endmodule

bind itlb_quad itlb_quad_chk u_itlb_quad_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_multi  (res_multi),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .miss_vaddr (miss_vaddr),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .ent_valid  (ent_valid)
);

// File: tb/test_itlb_quad.sv
module test_itlb_quad;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_MULTI = 2'd2;

  typedef struct packed {
    logic [31:0] vaddr;
    logic [7:0]  asid;
    logic        chk;
    logic [1:0]  kind;
    logic [1:0]  idx;
    logic [28:0] pa;
    logic [28:0] f_ppn;
    logic [7:0]  f_asid;
    logic [8:0]  f_flags;
  } vec_t;

  // flags: valid 0x100, size bits 0x080/0x010, user 0x040, shared 0x002
  localparam vec_t VECS [12] = '{
    '{32'h00401234, 8'd5, 1'b1, K_MISS,  2'd3, 29'h0C005234, 29'h0C005000, 8'd5, 9'h155}, // R4 R6 4K
    '{32'h00401FFC, 8'd5, 1'b1, K_HIT,   2'd3, 29'h0C005FFC, 29'h0,        8'd0, 9'h000}, // R1 R10
    '{32'h00402000, 8'd5, 1'b1, K_MISS,  2'd2, 29'h01000400, 29'h01000400, 8'd5, 9'h100}, // R4 1K
    '{32'h004023FF, 8'd5, 1'b1, K_HIT,   2'd2, 29'h010007FF, 29'h0,        8'd0, 9'h000}, // R1
    '{32'h12345678, 8'd5, 1'b1, K_MISS,  2'd1, 29'h05675678, 29'h05670000, 8'd9, 9'h182}, // R4 64K shared
    '{32'h12340000, 8'd7, 1'b1, K_HIT,   2'd1, 29'h05670000, 29'h0,        8'd0, 9'h000}, // R2 shared
    '{32'h00401000, 8'd6, 1'b1, K_MISS,  2'd0, 29'h0F001000, 29'h0F000000, 8'd6, 9'h190}, // R2 asid, R4 1M
    '{32'h00401000, 8'd5, 1'b0, K_MULTI, 2'd0, 29'h0,        29'h0,        8'd0, 9'h000}, // R3
    '{32'h00401000, 8'd5, 1'b1, K_HIT,   2'd3, 29'h0C005000, 29'h0,        8'd0, 9'h000}, // R5 touch 3
    '{32'h00480000, 8'd6, 1'b1, K_HIT,   2'd0, 29'h0F080000, 29'h0,        8'd0, 9'h000}, // R5 touch 0
    '{32'h00480000, 8'd7, 1'b1, K_MISS,  2'd2, 29'h02000000, 29'h02000000, 8'd7, 9'h150}, // R5 victim 2
    '{32'h00402000, 8'd5, 1'b1, K_MISS,  2'd1, 29'h03FFFC00, 29'h03FFFC00, 8'd5, 9'h100}  // R5 victim 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_asid_chk = 1'b0;
  logic        res_valid, res_hit, res_multi;
  logic [1:0]  res_idx;
  logic [28:0] res_paddr;
  logic        miss_valid;
  logic        miss_ready = 1'b0;
  logic [31:0] miss_vaddr;
  logic [7:0]  miss_asid;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [21:0] fill_vpn = '0;
  logic [18:0] fill_ppn = '0;
  logic [7:0]  fill_asid = '0;
  logic [8:0]  fill_flags = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_tag, rd_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itlb_quad i_itlb_quad (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_asid_chk(lk_asid_chk),
    .res_valid(res_valid), .res_hit(res_hit), .res_multi(res_multi),
    .res_idx(res_idx), .res_paddr(res_paddr),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .miss_asid(miss_asid),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_asid(fill_asid),
    .fill_flags(fill_flags),
    .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int hold);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = v.vaddr; lk_asid = v.asid; lk_asid_chk = v.chk;
    @(negedge clk);
    lk_valid = 1'b0;
    if (v.kind == K_MISS) begin
      check("R7 miss raised", 32'(miss_valid), 32'd1);
      check("R7 miss address", miss_vaddr, v.vaddr);
      check("R7 miss asid", 32'(miss_asid), 32'(v.asid));
      check("R12 no result on miss", 32'(res_valid), 32'd0);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check("R7 miss held", {miss_valid, lk_ready}, 32'b10);
        check("R7 miss address stable", miss_vaddr, v.vaddr);
      end
      miss_ready = 1'b1;
      @(negedge clk);
      miss_ready = 1'b0;
      check("R7 refill ready after accept", {miss_valid, fill_ready, lk_ready}, 32'b010);
      fill_valid = 1'b1;
      fill_vpn   = v.vaddr[31:10];
      fill_ppn   = v.f_ppn[28:10];
      fill_asid  = v.f_asid;
      fill_flags = v.f_flags;
      @(negedge clk);
      fill_valid = 1'b0;
      check("R7 lookup ready after refill", 32'(lk_ready), 32'd1);
    end
    check("R12 result pulse", 32'(res_valid), 32'd1);
    if (v.kind == K_MULTI) begin
      check("R3 multi flag", {res_multi, res_hit}, 32'b10);
    end else begin
      check("R2 hit flag", {res_multi, res_hit}, 32'b01);
      check("R4 R5 entry index", 32'(res_idx), 32'(v.idx));
      check("R10 physical address", 32'(res_paddr), 32'(v.pa));
    end
    @(negedge clk);
    check("R12 pulse is one cycle", 32'(res_valid), 32'd0);
  endtask

  task automatic read_entry(input logic [31:0] addr, input logic [31:0] tag, input logic [31:0] data);
    rd_addr = addr[8:7];
    #1;
    check("R9 tag word", rd_tag, tag);
    check("R6 R9 data word", rd_data, data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 lk_ready", 32'(lk_ready), 32'd1);
    check("R11 res_valid", 32'(res_valid), 32'd0);
    check("R11 miss_valid", 32'(miss_valid), 32'd0);
    check("R11 fill_ready", 32'(fill_ready), 32'd0);
    for (int e = 0; e < 4; e++) begin
      rd_addr = 2'(e);
      #1;
      check("R11 entry invalid", 32'(rd_tag[8]), 32'd0);
    end

    for (int i = 0; i < 12; i++) begin
      run_vec(VECS[i], (i == 0) ? 2 : 0);
    end

    // R9 inspection index from bits 8:7, R6 masked flags
    @(negedge clk);
    read_entry(32'h00000180, 32'h00401105, 32'h0C005150);
    read_entry(32'hFFFFFE7F, 32'h00401106, 32'h0F000190);
    read_entry(32'h00000080, 32'h00402105, 32'h03FFFD00);
    read_entry(32'h12345100, 32'h00480107, 32'h02000150);

    // R8 invalidate all
    @(negedge clk);
    flush = 1'b1;
    #1;
    check("R8 lookup blocked", 32'(lk_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    for (int e = 0; e < 4; e++) begin
      rd_addr = 2'(e);
      #1;
      check("R8 entry cleared", 32'(rd_tag[8]), 32'd0);
    end
    // code 0x30 after last refill selects entry 3 (R4); former hit now misses (R8)
    run_vec('{32'h00401000, 8'd5, 1'b1, K_MISS, 2'd3, 29'h0C005000,
              29'h0C005000, 8'd5, 9'h150}, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule